// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port synchronous memory array intended as the data store of a zero-wait-state secondary cache. Every control, address and write-data pin is taken on the rising clock edge. Read data leaves through an output register, so a read has a fixed two-edge pipeline. An access is opened by one of two address strobes: a processor strobe, which always reads, and a controller strobe, which reads or writes. Further words of a four-word burst are reached with an advance input, in either linear or interleaved order.

Three synchronous chip selects decide whether a strobe opens an access or deselects the device, which allows several devices to share a bus as banks. Writes use per-lane byte selects, or a global write that stores every lane. The data driver is off whenever a write is taken, and it is off for the first cycle of a read that leaves a deselected state. The output enable acts on the driver without any clocking. A sleep input puts the device in a snooze state in which all strobes are ignored. Normal operation returns on the third edge after sleep is released. Storage is retained through sleep.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read accepted at edge N puts the word on `dq_out` with `dq_oe` high from edge N+1 until edge N+2, provided `oe_n` is low and no write is taken at edge N+1. After reset `dq_oe` is low.
- R2: `ps_n` low with `sel1_n` low and all chip selects true starts a read at `adr`. This start is always a read, even when `glob_wr_n` or any `byte_sel_n` is low.
- R3: `cs_n` low with all chip selects true starts an access at `adr`. It is a write when `glob_wr_n` is low or any `byte_sel_n` bit is low. Otherwise it is a read.
- R4: `adv_n` low during an open access steps the burst position k (0 to 3) held in the two low address bits. Upper address bits stay fixed. With `lin_order`=1 the word address is base[1:0]+k mod 4. With `lin_order`=0 it is base[1:0] XOR k. A stepped cycle is a write when a write enable is active, and a read otherwise.
- R5: `byte_sel_n[i]` low writes lane i, which is bits 8i+7 down to 8i. Lanes whose select is high keep their old contents. `glob_wr_n` low writes all four lanes whatever the byte selects are.
- R6: The device is selected only when `sel1_n` is low, `sel2` is high and `sel3_n` is low at the strobe edge. A strobe edge with any select false deselects the device. A deselected device reads nothing and writes nothing, and it ignores `adv_n` until the next start.
- R7: `ps_n` is ignored while `sel1_n` is high. The `cs_n` strobe is still decoded at that edge.
- R8: In the cycle after a read starts from the deselected state, `dq_oe` stays low.
- R9: In the cycle after any write edge, `dq_oe` is low. This holds for partial byte writes as well.
- R10: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R11: While `sleep` is sampled high, and at the first two edges after it is sampled low, all strobes and writes are ignored and the device becomes deselected. Operation resumes at the third edge, and memory contents are kept.
- R12: An open access with no strobe and `adv_n` high re-reads the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Snooze request, active high |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| ps_n | input | 1 | Processor address strobe, active low |
| cs_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| adr | input | ADDR_W | Word address |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| byte_sel_n | input | NLANE | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | NLANE*LANE_W | Write data |
| dq_out | output | NLANE*LANE_W | Output register contents |
| dq_oe | output | 1 | Data driver enable (low means high impedance) |

## Verification
The bench builds the block with ADDR_W=6 (64 words) and keeps the default four 8-bit lanes. That depth lets a burst whose base is not lane-aligned wrap inside its four-word group, in both orders, while other words are held at known values and watched for corruption. The single-lane selects in the defaults expose each byte lane separately, so a mixed write can be checked lane by lane against a known background. The small depth keeps every address the bench touches distinct, so a write that should have been dropped shows as a changed word.

// File: rtl/sbsram_pkg.sv
// Shared types for the pipelined burst SRAM.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sbsram_pkg;
    // Operation decoded at each rising edge from pins and state
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_RD_LOAD,
        OP_WR_LOAD,
        OP_RD_STEP,
        OP_WR_STEP,
        OP_RD_HOLD
    } op_t;
endpackage

// File: rtl/burst_addr_gen.sv
// Burst address generator.
// Holds the base address of the open access and a 2-bit burst position.
// Produces the word address for the current edge: the pin address on a
// load, the next burst word on a step, otherwise the current word.
// Assumes ADDR_W >= 3 and a four-word burst held in the two low bits.
module burst_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              lin_mode,
    input  logic [ADDR_W-1:0] pin_adr,
    output logic [ADDR_W-1:0] acc_adr
);
    localparam int POS_W = 2;

    logic [ADDR_W-1:0] base_q;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_nxt;
    logic [POS_W-1:0]  low_bits;

    // Next burst position from load/step requests
    always_comb begin
        if (load)       pos_nxt = '0;
        else if (step)  pos_nxt = POS_W'(pos_q + 1'b1);
        else            pos_nxt = pos_q;
    end

    // Low address bits in linear or interleaved order
    always_comb begin
        if (lin_mode) low_bits = POS_W'(base_q[POS_W-1:0] + pos_nxt);
        else          low_bits = base_q[POS_W-1:0] ^ pos_nxt;
    end

    // Word address used for this edge
    always_comb begin
        if (load) acc_adr = pin_adr;
        else      acc_adr = {base_q[ADDR_W-1:POS_W], low_bits};
    end

    // Base and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            pos_q  <= '0;
        end else begin
            if (load) base_q <= pin_adr;
            pos_q <= pos_nxt;
        end
    end

    // A step never changes the upper address bits of the open access
    assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (acc_adr[ADDR_W-1:POS_W] == $past(acc_adr[ADDR_W-1:POS_W])) || load);
endmodule

// File: rtl/access_ctrl.sv
// Access controller.
// Decodes strobes, chip selects, advance and write enables into one
// operation per edge, tracks whether an access is open and gates all
// requests while sleeping and for two edges after wake-up.
// Assumes all pins are stable around the rising edge.
module access_ctrl
    import sbsram_pkg::*;
#(
    parameter int NLANE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             ps_n,
    input  logic             cs_n,
    input  logic             adv_n,
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             glob_wr_n,
    input  logic [NLANE-1:0] byte_sel_n,
    output logic             load,
    output logic             step,
    output logic             rd_go,
    output logic             wr_go,
    output logic [NLANE-1:0] byte_en,
    output logic             act_q
);
    localparam int WAKE_EDGES = 2;
    localparam int GATE_W     = $clog2(WAKE_EDGES + 1);

    op_t              op;
    logic [GATE_W-1:0] gate_q;
    logic             awake;
    logic             sel_ok;
    logic             wr_req;
    logic             p_go;

    assign awake  = !sleep && (gate_q == '0);
    assign sel_ok = !sel1_n && sel2 && !sel3_n;
    assign wr_req = !glob_wr_n || !(&byte_sel_n);
    assign p_go   = !ps_n && !sel1_n;

    // Operation decode: processor strobe first, then controller, then burst
    always_comb begin
        if (!awake)                op = OP_IDLE;
        else if (p_go)             op = sel_ok ? OP_RD_LOAD : OP_DESEL;
        else if (!cs_n)            op = !sel_ok ? OP_DESEL
                                      : (wr_req ? OP_WR_LOAD : OP_RD_LOAD);
        else if (act_q && !adv_n)  op = wr_req ? OP_WR_STEP : OP_RD_STEP;
        else if (act_q)            op = OP_RD_HOLD;
        else                       op = OP_IDLE;
    end

    // Strobes into generator and array requests
    always_comb begin
        load    = (op == OP_RD_LOAD) || (op == OP_WR_LOAD);
        step    = (op == OP_RD_STEP) || (op == OP_WR_STEP);
        wr_go   = (op == OP_WR_LOAD) || (op == OP_WR_STEP);
        rd_go   = (op == OP_RD_LOAD) || (op == OP_RD_STEP) || (op == OP_RD_HOLD);
        byte_en = glob_wr_n ? ~byte_sel_n : '1;
    end

    // Open-access flag and wake-up gate counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            gate_q <= '0;
        end else if (sleep) begin
            act_q  <= 1'b0;
            gate_q <= GATE_W'(WAKE_EDGES);
        end else begin
            if (gate_q != '0) gate_q <= gate_q - 1'b1;
            if (op == OP_DESEL)  act_q <= 1'b0;
            else if (load)       act_q <= 1'b1;
        end
    end

    // A processor-strobe edge never produces a write
    assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n && !sel1_n) |-> !wr_go);

    // Without an open access and without strobes nothing is read or written
    assert_desel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && ps_n && cs_n) |-> !(rd_go || wr_go));

    // The edge after sleep is sampled takes no access
    assert_snooze_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !(rd_go || wr_go || load));

    // The second edge after sleep is sampled takes no access either
    assert_wake_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && $past(sleep)) |=> !(rd_go || wr_go || load));
endmodule

// File: rtl/sram_array.sv
// Storage array with byte-lane writes and a two-stage read pipeline.
// A write is committed at the edge that takes it. A read registers its
// address at that edge and loads the output register one edge later.
// The drive flag is low after any write edge. Storage is not reset.
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int NLANE  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       adr,
    input  logic [NLANE-1:0]        byte_en,
    input  logic [NLANE*LANE_W-1:0] wdata,
    output logic [NLANE*LANE_W-1:0] rdata,
    output logic                    drv
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NLANE * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rd_adr_q;
    logic              rd_q;
    logic              vld_q;
    logic              wr_seen_q;
    logic [DATA_W-1:0] dout_q;

    // Per-lane write into storage
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLANE; i++) begin
            if (wr_en && byte_en[i])
                mem[adr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    // Read pipeline: address stage, then output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_adr_q  <= '0;
            rd_q      <= 1'b0;
            vld_q     <= 1'b0;
            wr_seen_q <= 1'b0;
            dout_q    <= '0;
        end else begin
            rd_adr_q  <= adr;
            rd_q      <= rd_en;
            vld_q     <= rd_q;
            wr_seen_q <= wr_en;
            if (rd_q) dout_q <= mem[rd_adr_q];
        end
    end

    assign rdata = dout_q;
    assign drv   = vld_q && !wr_seen_q;

    // Read data becomes valid two edges after the read is taken
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ##2 vld_q);

    // Driver is off in the cycle after any write edge
    assert_write_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !drv);
endmodule

// File: rtl/pipe_burst_sram.sv
// Pipelined synchronous burst SRAM, top level.
// Connects the access controller, the burst address generator and the
// storage array. The output enable gates the data driver combinationally.
// Assumes a single clock domain and a synchronous active-low reset.
module pipe_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int NLANE  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    lin_order,
    input  logic                    ps_n,
    input  logic                    cs_n,
    input  logic                    adv_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic [ADDR_W-1:0]       adr,
    input  logic                    glob_wr_n,
    input  logic [NLANE-1:0]        byte_sel_n,
    input  logic                    oe_n,
    input  logic [NLANE*LANE_W-1:0] wdata,
    output logic [NLANE*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    logic              load;
    logic              step;
    logic              rd_go;
    logic              wr_go;
    logic              act_q;
    logic              drv;
    logic [NLANE-1:0]  byte_en;
    logic [ADDR_W-1:0] acc_adr;

    access_ctrl #(.NLANE(NLANE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .ps_n       (ps_n),
        .cs_n       (cs_n),
        .adv_n      (adv_n),
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .glob_wr_n  (glob_wr_n),
        .byte_sel_n (byte_sel_n),
        .load       (load),
        .step       (step),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .byte_en    (byte_en),
        .act_q      (act_q)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .lin_mode (lin_order),
        .pin_adr  (adr),
        .acc_adr  (acc_adr)
    );

    sram_array #(.ADDR_W(ADDR_W), .NLANE(NLANE), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .rd_en   (rd_go),
        .adr     (acc_adr),
        .byte_en (byte_en),
        .wdata   (wdata),
        .rdata   (dq_out),
        .drv     (drv)
    );

    // Asynchronous output enable on the driver
    assign dq_oe = drv && !oe_n;

    // A read that leaves the deselected state is not driven in its first cycle
    assert_first_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && rd_go) |=> !drv);
endmodule

// File: tb/pipe_burst_sram_test.sv
// Directed bench for the pipelined burst SRAM: one task per scenario.
module pipe_burst_sram_test;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep, lin_order, ps_n, cs_n, adv_n;
    logic          sel1_n, sel2, sel3_n, glob_wr_n, oe_n;
    logic [AW-1:0] adr;
    logic [3:0]    byte_sel_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    int            checks = 0;
    int            errors = 0;

    pipe_burst_sram #(.ADDR_W(AW), .NLANE(4), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .lin_order(lin_order),
        .ps_n(ps_n), .cs_n(cs_n), .adv_n(adv_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .adr(adr), .glob_wr_n(glob_wr_n),
        .byte_sel_n(byte_sel_n), .oe_n(oe_n), .wdata(wdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pins_idle();
        ps_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
        glob_wr_n = 1'b1; byte_sel_n = 4'hF;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0; sleep = 1'b0;
    endtask

    task automatic deselect_pins();
        pins_idle(); cs_n = 1'b0; sel2 = 1'b0;
    endtask

    // Single controller-strobe write, then deselect
    task automatic wr_one(input int a, input logic [31:0] d,
                          input logic g_n, input logic [3:0] bs_n);
        pins_idle(); cs_n = 1'b0; adr = AW'(a); wdata = d;
        glob_wr_n = g_n; byte_sel_n = bs_n;
        tick();
        deselect_pins();
        tick();
        pins_idle();
    endtask

    // Single processor-strobe read from the deselected state
    task automatic rd_one(input int a, input logic [31:0] exp, input string req);
        pins_idle(); ps_n = 1'b0; adr = AW'(a);
        tick();
        chk(!dq_oe, "R8 first read cycle undriven", 32'(dq_oe), 32'd0);
        deselect_pins();
        tick();
        chk(dq_oe && dq_out == exp, req, dq_out, exp);
        pins_idle();
    endtask

    task automatic t_lanes();
        wr_one(3, 32'hAABBCCDD, 1'b0, 4'hF);
        rd_one(3, 32'hAABBCCDD, "R3 controller write then read");
        wr_one(3, 32'h11223344, 1'b1, 4'b1010);
        rd_one(3, 32'hAA22CC44, "R5 lanes 0 and 2 only");
        wr_one(3, 32'h55667788, 1'b0, 4'b1110);
        rd_one(3, 32'h55667788, "R5 global write overrides selects");
    endtask

    task automatic t_proc_read_only();
        pins_idle(); ps_n = 1'b0; adr = AW'(3);
        glob_wr_n = 1'b0; byte_sel_n = 4'h0; wdata = 32'hDEADBEEF;
        tick();
        deselect_pins();
        tick();
        chk(dq_oe && dq_out == 32'h55667788, "R2 processor strobe reads",
            dq_out, 32'h55667788);
        pins_idle();
        rd_one(3, 32'h55667788, "R2 no write on processor strobe");
    endtask

    task automatic t_burst_read(input bit lin, input int base);
        pins_idle(); lin_order = lin; ps_n = 1'b0; adr = AW'(base);
        tick();
        for (int k = 0; k < 4; k++) begin
            int a;
            if (k < 3) begin pins_idle(); adv_n = 1'b0; end
            else deselect_pins();
            tick();
            a = lin ? ((base & ~3) | ((base + k) & 3)) : (base ^ k);
            chk(dq_oe && dq_out == 32'h100 + 32'(a),
                lin ? "R4 linear burst" : "R4 interleaved burst",
                dq_out, 32'h100 + 32'(a));
        end
        pins_idle();
        lin_order = 1'b1;
    endtask

    task automatic t_burst_write();
        int seq [4] = '{9, 10, 11, 8};
        pins_idle(); lin_order = 1'b1; cs_n = 1'b0; adr = AW'(9);
        glob_wr_n = 1'b0; wdata = 32'hC0DE0000;
        tick();
        for (int k = 1; k < 4; k++) begin
            pins_idle(); adv_n = 1'b0; glob_wr_n = 1'b0;
            wdata = 32'hC0DE0000 + 32'(k);
            tick();
            chk(!dq_oe, "R9 driver off during burst write", 32'(dq_oe), 32'd0);
        end
        deselect_pins();
        tick();
        pins_idle();
        for (int k = 0; k < 4; k++)
            rd_one(seq[k], 32'hC0DE0000 + 32'(k), "R4 burst write order");
    endtask

    task automatic t_ignore_proc();
        pins_idle(); ps_n = 1'b0; adr = AW'(4);
        tick();
        pins_idle(); ps_n = 1'b0; sel1_n = 1'b1; adr = AW'(8);
        tick();
        chk(dq_oe && dq_out == 32'h104, "R1 read data one edge later",
            dq_out, 32'h104);
        deselect_pins();
        tick();
        chk(dq_oe && dq_out == 32'h104, "R7 R12 ignored strobe, hold re-read",
            dq_out, 32'h104);
        pins_idle();
    endtask

    task automatic t_deselect();
        pins_idle(); ps_n = 1'b0; adr = AW'(4); sel3_n = 1'b1;
        tick();
        pins_idle(); adv_n = 1'b0;
        tick();
        chk(!dq_oe, "R6 deselected strobe reads nothing", 32'(dq_oe), 32'd0);
        pins_idle();
        tick();
        chk(!dq_oe, "R6 advance ignored while deselected", 32'(dq_oe), 32'd0);
        pins_idle(); cs_n = 1'b0; sel2 = 1'b0; adr = AW'(4);
        glob_wr_n = 1'b0; wdata = 32'hBADBAD00;
        tick();
        pins_idle();
        tick();
        rd_one(4, 32'h104, "R6 write dropped when not selected");
    endtask

    task automatic t_output_enable();
        pins_idle(); ps_n = 1'b0; adr = AW'(5);
        tick();
        deselect_pins(); oe_n = 1'b1;
        tick();
        chk(!dq_oe, "R10 oe_n high blocks driver", 32'(dq_oe), 32'd0);
        oe_n = 1'b0;
        #1;
        chk(dq_oe && dq_out == 32'h105, "R10 driver follows oe_n at once",
            dq_out, 32'h105);
        tick();
        pins_idle();
    endtask

    task automatic t_write_hiz();
        pins_idle(); ps_n = 1'b0; adr = AW'(4);
        tick();
        pins_idle(); cs_n = 1'b0; adr = AW'(12);
        byte_sel_n = 4'b1101; wdata = 32'h0000EE00;
        tick();
        chk(!dq_oe, "R9 partial write turns driver off", 32'(dq_oe), 32'd0);
        deselect_pins();
        tick();
        pins_idle();
        rd_one(12, 32'h0000EE00 | 32'h0, "R9 partial write stored");
    endtask

    task automatic t_sleep();
        pins_idle(); sleep = 1'b1; cs_n = 1'b0; adr = AW'(4);
        glob_wr_n = 1'b0; wdata = 32'hBADBAD11;
        tick();
        pins_idle(); ps_n = 1'b0; adr = AW'(4);
        tick();
        tick();
        tick();
        chk(!dq_oe, "R11 reads ignored for two edges after wake", 32'(dq_oe), 32'd0);
        deselect_pins();
        tick();
        chk(dq_oe && dq_out == 32'h104, "R11 resumes at third edge, data kept",
            dq_out, 32'h104);
        pins_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b0; lin_order = 1'b1;
        adr = '0; wdata = '0;
        pins_idle();
        repeat (3) tick();
        chk(!dq_oe, "R1 driver off in reset", 32'(dq_oe), 32'd0);
        rst_n = 1'b1;
        tick();
        chk(!dq_oe, "R1 driver off after reset", 32'(dq_oe), 32'd0);
        // word i at addresses 4..7 holds 0x100+i (12 is written later)
        for (int i = 4; i < 8; i++) wr_one(i, 32'h100 + 32'(i), 1'b0, 4'hF);
        wr_one(12, 32'h0, 1'b0, 4'hF);
        t_lanes();
        t_proc_read_only();
        t_burst_read(1'b1, 5);
        t_burst_read(1'b0, 5);
        t_burst_read(1'b0, 6);
        t_burst_write();
        t_ignore_proc();
        t_deselect();
        t_output_enable();
        t_write_hiz();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule